// File: doc/BRIEF.md
# External Static-Memory Chip-Select Controller

This block sits between an internal request port and an external static-memory bus. It decodes a 32-bit request address into one of four chip selects, each owning a fixed 16 MB window, and runs the external bus cycle for it. The bus cycle drives active-low chip selects, an output strobe, a write strobe, byte-lane selects, a 24-bit byte address and a 32-bit data bus. Every chip select has its own configuration word. That word sets the device width, the read and write wait counts, the turnaround idle count, byte-lane qualification and write protection.

A request whose size is larger than the device width is split into consecutive bus cycles at rising byte offsets. Read data is gathered back into lane-aligned position before a single response is returned. Chip select 0 can come out of reset already set up for an external boot: its width comes from two strap inputs, and its timing is slow enough for any device.

Top module: `ext_cs_bus_ctrl`

## Requirements
- R1: A request with address bits [31:26] equal to 100000 selects the chip select numbered by bits [25:24]. During its bus cycles only that bit of `cs_n` is low (active low), so chip select n covers 0x80000000 + n*16 MB.
- R2: Each of the four chip selects has a configuration word, written when `cfg_we` is high with `cfg_sel` as the index. The fields are: idle count [4:0], read wait [10:5], byte-lane enable [11], write wait [17:12], write protect [18], and width [20:19], where 00 is 8 bits, 01 is 16 bits and 10 is 32 bits.
- R3: After reset, chip selects 1 to 3 hold width 32, read and write wait DEF_WAIT (15), idle DEF_IDLE (15), and byte lanes and protection off. Chip select 0 resets the same way when `boot_strap` is 11. Otherwise it takes its width from `boot_strap`, read and write wait 34 and idle 16. Out of reset, `req_ready` is 1, every strobe is high and `wp_err` is 0.
- R4: Each bus cycle keeps `cs_n` and its strobe low for wait+1 clocks. A read uses `oe_n` and the read wait; a write uses `we_n` and the write wait. `oe_n` and `we_n` are never low together.
- R5: A request of 2^s bytes to a device of 2^w bytes with s > w becomes 2^(s-w) bus cycles, back to back, with `ext_addr[1:0]` stepping by 2^w from the aligned request base. Otherwise it takes one bus cycle at the address aligned to the device width. On a 32-bit device, `ext_addr[1:0]` is always 00.
- R6: One clock after the last strobe clock, `rsp_valid` pulses for one cycle. Every device byte sampled at the end of each bus cycle sits in `rsp_rdata` at its own byte lane, and the other lanes are zero. Writes answer with zero data.
- R7: Between two back-to-back accesses, all of `cs_n`, `oe_n` and `we_n` stay high for exactly idle+1 clocks, where idle is the count of the access that just ended.
- R8: With byte lanes enabled, `bls_n` is low only on the device lanes the request covers. With them disabled, writes drive all of `bls_n` low and reads drive it all high.
- R9: A write to a protected chip select runs no bus cycle and answers one clock after acceptance. It sets `wp_err`, which stays set until reset.
- R10: Write data is taken from the request lanes at the current byte offset and repeated across `ext_dout` at the device width. `ext_doe` is high only during write strobes.
- R11: A request outside the four windows runs no bus cycle and answers one clock later with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap | input | 2 | Boot width straps for chip select 0 (11 = no external boot) |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_sel | input | 2 | Chip select whose word is written |
| cfg_wdata | input | 21 | Configuration word |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | 32 | Request byte address, naturally aligned |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 = byte, 1 = half word, 2 = word |
| req_wdata | input | 32 | Lane-aligned write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Lane-aligned read data |
| wp_err | output | 1 | Sticky protected-write flag |
| cs_n | output | 4 | Chip selects, active low |
| oe_n | output | 1 | Output enable strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| bls_n | output | 4 | Byte-lane selects, active low |
| ext_addr | output | 24 | External byte address |
| ext_dout | output | 32 | External write data |
| ext_doe | output | 1 | Data bus drive enable |
| ext_din | input | 32 | External read data |

## Verification
The assertions check properties that hold on every cycle. At most one chip select is active at a time. The two strobes never overlap. All strobes stay quiet while a turnaround count is running. A 32-bit device never sees a non-zero low address. The protection flag never clears once set. Exact strobe lengths, bus-cycle counts and offset sequences for narrow devices, data-lane assembly, the byte-lane patterns and the idle-gap length can only be shown by the bench scenarios. The bench compares these against an independent memory model and its own arithmetic.

// File: rtl/ext_cs_bus_ctrl.sv
module ext_cs_bus_ctrl #(
  parameter int BOOT_WAIT = 34,
  parameter int BOOT_IDLE = 16,
  parameter int DEF_WAIT  = 15,
  parameter int DEF_IDLE  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  boot_strap,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [20:0] cfg_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        req_write,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  output logic [31:0] rsp_rdata,
  output logic        wp_err,
  output logic [3:0]  cs_n,
  output logic        oe_n,
  output logic        we_n,
  output logic [3:0]  bls_n,
  output logic [23:0] ext_addr,
  output logic [31:0] ext_dout,
  output logic        ext_doe,
  input  logic [31:0] ext_din
);
  localparam int CW = 21;

  function automatic logic [CW-1:0] pack_cfg(input logic [1:0] w, input logic [5:0] rw,
      input logic [5:0] ww, input logic [4:0] idl, input logic ble, input logic wp);
    return {w, wp, ww, ble, rw, idl};
  endfunction

  function automatic logic [1:0] lmask(input logic [1:0] n);
    return (n == 2'd0) ? 2'b00 : (n == 2'd1) ? 2'b01 : 2'b11;
  endfunction

  function automatic logic [3:0] bmask(input logic [1:0] n);
    return (n == 2'd0) ? 4'h1 : (n == 2'd1) ? 4'h3 : 4'hF;
  endfunction

  localparam logic [CW-1:0] DEF_CFG =
    pack_cfg(2'd2, 6'(DEF_WAIT), 6'(DEF_WAIT), 5'(DEF_IDLE), 1'b0, 1'b0);

  logic [CW-1:0] cfg [4];
  logic        busy, we_q, ble_q;
  logic [1:0]  cs_q, sz_q, wd_q, beat;
  logic [5:0]  wst_q, cnt;
  logic [4:0]  idl_q, gap;
  logic [23:0] a_q;
  logic [31:0] wbuf, rd_q;

  wire [CW-1:0] sel_cfg = cfg[req_addr[25:24]];
  wire          in_win  = (req_addr[31:26] == 6'b100000);
  wire          accept  = req_valid && req_ready;
  wire          big     = (sz_q > wd_q);
  wire [1:0]    span    = big ? sz_q : wd_q;
  wire [1:0]    off     = (a_q[1:0] & ~lmask(span)) + 2'(beat << wd_q);
  wire [1:0]    last    = !big ? 2'd0 : ((sz_q - wd_q) == 2'd2) ? 2'd3 : 2'd1;
  wire [3:0]    lanes   = big ? bmask(wd_q) : 4'(bmask(sz_q) << (a_q[1:0] & lmask(wd_q)));

  assign req_ready = !busy && (gap == 5'd0);
  assign cs_n      = busy ? ~(4'b0001 << cs_q) : 4'hF;
  assign oe_n      = !(busy && !we_q);
  assign we_n      = !(busy && we_q);
  assign ext_doe   = busy && we_q;
  assign bls_n     = !busy ? 4'hF : ble_q ? ~lanes : we_q ? 4'h0 : 4'hF;
  assign ext_addr  = {a_q[23:2], off};
  assign rsp_rdata = rd_q;

  always_comb begin
    case (wd_q)
      2'd0:    ext_dout = {4{wbuf[{off, 3'b000} +: 8]}};
      2'd1:    ext_dout = {2{wbuf[{off[1], 4'b0000} +: 16]}};
      default: ext_dout = wbuf;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg[0] <= (boot_strap == 2'b11) ? DEF_CFG :
                pack_cfg(boot_strap, 6'(BOOT_WAIT), 6'(BOOT_WAIT), 5'(BOOT_IDLE), 1'b0, 1'b0);
      for (int i = 1; i < 4; i++) cfg[i] <= DEF_CFG;
      busy <= 1'b0; we_q <= 1'b0; ble_q <= 1'b0; cs_q <= '0; sz_q <= '0; wd_q <= '0;
      beat <= '0; wst_q <= '0; cnt <= '0; idl_q <= '0; gap <= '0; a_q <= '0;
      wbuf <= '0; rd_q <= '0; rsp_valid <= 1'b0; wp_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (cfg_we) cfg[cfg_sel] <= cfg_wdata;
      if (gap != 5'd0) gap <= gap - 5'd1;
      if (accept) begin
        rd_q <= '0;
        if (!in_win || (req_write && sel_cfg[18])) begin
          rsp_valid <= 1'b1;
          if (in_win) wp_err <= 1'b1;
        end else begin
          busy  <= 1'b1;
          cs_q  <= req_addr[25:24];
          a_q   <= req_addr[23:0];
          sz_q  <= req_size;
          we_q  <= req_write;
          wbuf  <= req_wdata;
          wd_q  <= sel_cfg[20:19];
          ble_q <= sel_cfg[11];
          idl_q <= sel_cfg[4:0];
          wst_q <= req_write ? sel_cfg[17:12] : sel_cfg[10:5];
          cnt   <= req_write ? sel_cfg[17:12] : sel_cfg[10:5];
          beat  <= '0;
        end
      end
      if (busy) begin
        if (cnt != 6'd0) cnt <= cnt - 6'd1;
        else begin
          if (!we_q) begin
            case (wd_q)
              2'd0:    rd_q[{off, 3'b000} +: 8] <= ext_din[7:0];
              2'd1:    rd_q[{off[1], 4'b0000} +: 16] <= ext_din[15:0];
              default: rd_q <= ext_din;
            endcase
          end
          if (beat == last) begin
            busy <= 1'b0;
            rsp_valid <= 1'b1;
            gap <= idl_q;
          end else begin
            beat <= beat + 2'd1;
            cnt  <= wst_q;
          end
        end
      end
    end
  end

  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n) !(!oe_n && !we_n));
  assert_word_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wd_q == 2'd2) |-> (ext_addr[1:0] == 2'b00));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gap != 5'd0) |-> (cs_n == 4'hF && oe_n && we_n));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n) wp_err |=> wp_err);
endmodule

// File: tb/ext_cs_bus_ctrl_test.sv
module ext_cs_bus_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] boot_strap = 2'b00;
  logic cfg_we = 1'b0; logic [1:0] cfg_sel = '0; logic [20:0] cfg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0; logic [31:0] req_addr = '0, req_wdata = '0;
  logic [1:0] req_size = '0;
  logic req_ready, rsp_valid, wp_err, oe_n, we_n, ext_doe;
  logic [31:0] rsp_rdata, ext_dout, ext_din;
  logic [3:0] cs_n, bls_n; logic [23:0] ext_addr;

  ext_cs_bus_ctrl uut (.clk, .rst_n, .boot_strap, .cfg_we, .cfg_sel, .cfg_wdata,
    .req_valid, .req_ready, .req_addr, .req_write, .req_size, .req_wdata,
    .rsp_valid, .rsp_rdata, .wp_err, .cs_n, .oe_n, .we_n, .bls_n,
    .ext_addr, .ext_dout, .ext_doe, .ext_din);

  always #5 clk = ~clk;

  int total = 0, bad = 0;
  logic [31:0] expq[$];
  int dev_w[4] = '{0, 2, 2, 2};

  int n_oe, n_we, n_beat, run, last_run;
  logic [1:0] boff[8];
  logic [3:0] s_bls, s_cs; logic [31:0] s_dout; logic [23:0] s_addr; logic prev_str;

  function automatic logic [7:0] mb(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always_comb begin
    int c = 0;
    for (int i = 0; i < 4; i++) if (!cs_n[i]) c = i;
    case (dev_w[c])
      0: ext_din = {24'hEEEEEE, mb(ext_addr)};
      1: ext_din = {16'hEEEE, mb({ext_addr[23:1], 1'b1}), mb({ext_addr[23:1], 1'b0})};
      default: ext_din = {mb({ext_addr[23:2], 2'd3}), mb({ext_addr[23:2], 2'd2}),
                          mb({ext_addr[23:2], 2'd1}), mb({ext_addr[23:2], 2'd0})};
    endcase
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [31:0] a, input int sz, input int w);
    logic [31:0] r = '0;
    int sp = ((1 << sz) > (1 << w)) ? (1 << sz) : (1 << w);
    int base = int'(a[1:0]) & ~(sp - 1);
    for (int i = 0; i < 4; i++)
      if (i >= base && i < base + sp) r[i*8 +: 8] = mb({a[23:2], 2'(i)});
    return r;
  endfunction

  function automatic logic [20:0] mk(input int w, input int rw, input int ww, input int idl,
                                     input bit ble, input bit wp);
    return {2'(w), wp, 6'(ww), ble, 6'(rw), 5'(idl)};
  endfunction

  // monitor: scoreboard pop and bus observation
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (expq.size() == 0) chk("R6 unexpected response", rsp_rdata, 32'hX);
        else chk("R6 R11 response data", rsp_rdata, expq.pop_front());
      end
      if (!oe_n || !we_n) begin
        if (!oe_n) n_oe++;
        if (!we_n) n_we++;
        if (!prev_str || ext_addr != s_addr) begin
          if (n_beat < 8) boff[n_beat] = ext_addr[1:0];
          n_beat++;
        end
        s_addr = ext_addr; s_bls = bls_n; s_cs = cs_n; s_dout = ext_dout;
        prev_str = 1'b1;
      end else prev_str = 1'b0;
      if (cs_n == 4'hF) run++;
      else begin
        if (run > 0) last_run = run;
        run = 0;
      end
    end
  end

  task automatic clr_mon();
    n_oe = 0; n_we = 0; n_beat = 0; run = 0; last_run = 0; prev_str = 1'b0;
    s_bls = 4'hF; s_cs = 4'hF; s_dout = '0; s_addr = '0;
  endtask

  task automatic cfg(input int s, input logic [20:0] v, input int w);
    cfg_we = 1'b1; cfg_sel = 2'(s); cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
    dev_w[s] = w;
  endtask

  // driver: issue request, push expected response
  task automatic req(input logic [31:0] a, input bit wr, input int sz, input logic [31:0] wd,
                     input logic [31:0] exp);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = 2'(sz); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    expq.push_back(exp);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic settle();
    do @(negedge clk); while (expq.size() != 0 || cs_n != 4'hF);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    clr_mon();
    chk("R3 reset ready", 32'(req_ready), 1);
    chk("R3 reset strobes", {26'd0, cs_n, oe_n, we_n}, {26'd0, 4'hF, 1'b1, 1'b1});
    chk("R3 reset err", 32'(wp_err), 0);

    // boot strap 00: cs0 8-bit, wait 34 -> word read is 4 bus cycles of 35 clocks
    clr_mon();
    req(32'h8000_0104, 0, 2, '0, exp_rd(32'h8000_0104, 2, 0));
    settle();
    chk("R3 R4 cs0 boot read strobe clocks", n_oe, 140);
    chk("R5 cs0 8-bit bus cycles", n_beat, 4);
    chk("R5 cs0 offsets", {24'd0, boff[0], boff[1], boff[2], boff[3]}, {24'd0, 8'b00_01_10_11});
    chk("R1 cs0 select", 32'(s_cs), 32'h0000000E);

    // cs1 default: 32-bit, wait 15
    clr_mon();
    req(32'h8100_0010, 0, 2, '0, exp_rd(32'h8100_0010, 2, 2));
    settle();
    chk("R3 cs1 default wait", n_oe, 16);
    chk("R1 cs1 select", 32'(s_cs), 32'h0000000D);

    // R2: cs2 16-bit, read wait 2, write wait 1, idle 3, byte lanes on
    cfg(2, mk(1, 2, 1, 3, 1'b1, 1'b0), 1);
    clr_mon();
    req(32'h8200_0020, 0, 2, '0, exp_rd(32'h8200_0020, 2, 1));
    settle();
    chk("R2 R4 cs2 read clocks", n_oe, 6);
    chk("R5 cs2 16-bit bus cycles", n_beat, 2);
    chk("R5 cs2 offsets", {28'd0, boff[0], boff[1]}, {28'd0, 4'b00_10});
    clr_mon();
    req(32'h8200_0033, 1, 0, 32'hA7_00_00_00, 32'h0);
    settle();
    chk("R4 cs2 write clocks", n_we, 2);
    chk("R8 cs2 byte lane", 32'(s_bls), 32'h0000000D);
    chk("R5 cs2 byte addr", 32'(s_addr[1:0]), 2);
    chk("R10 cs2 write data", 32'(s_dout[15:8]), 32'hA7);

    // cs3 32-bit, read wait 1, write wait 0, idle 2, lanes off, protected
    cfg(3, mk(2, 1, 0, 2, 1'b0, 1'b1), 2);
    clr_mon();
    req(32'h8300_0040, 1, 2, 32'h1234_5678, 32'h0);
    settle();
    chk("R9 protected write no strobe", n_we, 0);
    chk("R9 err set", 32'(wp_err), 1);
    clr_mon();
    req(32'h8300_0041, 0, 0, '0, exp_rd(32'h8300_0041, 0, 2));
    settle();
    chk("R8 read lanes off", 32'(s_bls), 32'h0000000F);
    chk("R5 word device addr", 32'(s_addr[1:0]), 0);
    chk("R9 err sticky", 32'(wp_err), 1);

    // R7: back-to-back reads on cs3, idle 2 -> 3 quiet clocks
    clr_mon();
    req(32'h8300_0050, 0, 2, '0, exp_rd(32'h8300_0050, 2, 2));
    req(32'h8300_0054, 0, 2, '0, exp_rd(32'h8300_0054, 2, 2));
    settle();
    chk("R7 idle gap", last_run, 3);

    // cs1 reconfigured: 32-bit, write wait 0, lanes off
    cfg(1, mk(2, 0, 0, 0, 1'b0, 1'b0), 2);
    clr_mon();
    req(32'h8100_0002, 1, 1, 32'hBEEF_0000, 32'h0);
    settle();
    chk("R4 cs1 write clocks", n_we, 1);
    chk("R8 write lanes off", 32'(s_bls), 32'h00000000);
    chk("R10 full-width data", s_dout, 32'hBEEF_0000);

    // R11: outside the windows
    clr_mon();
    req(32'h4000_0000, 0, 2, '0, 32'h0);
    settle();
    chk("R11 no strobes", n_oe + n_we, 0);

    chk("R6 scoreboard drained", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule